// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with a two-address register interface. The data address is shared by both directions. A write to it starts a transmission. A read from it returns the last completed received word from a holding latch. That latch is separate from the receive shifter, so a new frame can arrive while software has not yet collected the previous one. The control address holds the frame mode, the receive gate, the transmit and receive ninth bits, the interrupt enable, and two sticky completion flags. Together these form one interrupt line.

Frames idle high. Each frame is a low start bit, then the data bits least significant first, then an optional ninth bit, then one high stop bit. Every bit lasts `OSR` pulses of the `tick16` strobe, which an external rate generator supplies. On receive, a falling edge on the line starts a frame. The start bit is re-checked at its middle, and every later bit is sampled at its centre.

The transmitter has two states. `TX_IDLE` moves to `TX_SEND` on a data write. `TX_SEND` returns to `TX_IDLE` when the zero detector finds only the marker bit left in the shifter. The receiver has four states: `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`. `RX_IDLE` moves to `RX_START` on a falling edge while receive is enabled. `RX_START` moves to `RX_DATA` if the line is still low at mid-bit, and otherwise returns to `RX_IDLE`. `RX_DATA` moves to `RX_STOP` after the last data bit. `RX_STOP` returns to `RX_IDLE`, and delivers the word only if the line is high there. Clearing the receive gate sends any state back to `RX_IDLE`.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00, the data address reads 0x00, `txd` is high and `irq` is low.
- R2: In 8-bit mode (control bit 0 clear), a write to the data address (`addr`=1) sends a low start bit, the 8 data bits LSB first and a high stop bit, each lasting `OSR` ticks. When the frame ends, the transmit-done flag (control bit 5) is set.
- R3: In 9-bit mode (control bit 0 set), the transmitted frame carries control bit 2 as the ninth bit, between the eighth data bit and the stop bit.
- R4: A data-address write made while a frame is being sent is ignored. The frame in flight is unchanged, and no second frame follows it.
- R5: With receive enabled (control bit 1), a valid 8-bit frame puts its byte on data-address reads and sets the receive-done flag (control bit 6). The receive-ninth-bit field (control bit 3) keeps its value.
- R6: In 9-bit mode, a received frame's ninth bit is written into control bit 3, and its low 8 bits go to the data latch.
- R7: The data latch keeps the previous word while the next frame is being shifted in, and it is replaced only when that next frame completes.
- R8: A frame whose stop bit is low is discarded. The receive-done flag stays clear and the data latch is unchanged.
- R9: A low pulse shorter than half a bit time is not taken as a start bit, and the receiver then accepts the following valid frame.
- R10: While control bit 1 is clear, no frame is received. The flag and the data latch are unchanged.
- R11: The done flags are sticky. Data reads, data writes and other frames leave them set. A control write clears a flag only if that bit of the written value is 0.
- R12: `irq` equals control bit 4 ANDed with the OR of the two done flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle rate strobe, `OSR` per bit time |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control, 1 = data |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined completion interrupt |

## Verification
The bench uses the default parameters: `OSR` = 16 and `DATA_W` = 8. It raises `tick16` once every four clocks, so one bit lasts 64 clocks. At that rate the bench can sample each bit at its centre with several clocks of margin. It can also cover both frame lengths and back-to-back receive frames within a few thousand cycles. It can place a glitch of a quarter bit well inside the half-bit start check, and it can overlap a latch read with a frame still being shifted in.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [0:0] {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    // control register bit positions
    localparam int CB_MODE9   = 0;
    localparam int CB_RXEN    = 1;
    localparam int CB_TXB9    = 2;
    localparam int CB_RXB9    = 3;
    localparam int CB_IRQEN   = 4;
    localparam int CB_TXDONE  = 5;
    localparam int CB_RXDONE  = 6;

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              mode9,
    input  logic              bit9,
    output logic              txd,
    output logic              busy,
    output logic              fin
);
    localparam int SH_W  = DATA_W + 4;
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

    tx_state_t         state_q, state_n;
    logic [SH_W-1:0]   shreg_q, shreg_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [SH_W-1:0]   frame8, frame9;

    // marker 1 sits above the stop bit; shifting in zeros leaves it alone at the end
    assign frame8 = {1'b0, 1'b1, 1'b1, load_data, 1'b0};
    assign frame9 = {1'b1, 1'b1, bit9, load_data, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            shreg_q <= shreg_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        shreg_n = shreg_q;
        cnt_n   = cnt_q;
        fin     = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (load) begin
                    shreg_n = mode9 ? frame9 : frame8;
                    cnt_n   = '0;
                    state_n = TX_SEND;
                end
            end
            TX_SEND: begin
                if (tick) begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_n   = '0;
                        shreg_n = shreg_q >> 1;
                        if (shreg_n[SH_W-1:1] == '0) begin
                            state_n = TX_IDLE;
                            fin     = 1'b1;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = TX_IDLE;
        endcase
    end

    assign busy = (state_q == TX_SEND);
    assign txd  = busy ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              enable,
    input  logic              mode9,
    output logic              fin,
    output logic [DATA_W-1:0] data_out,
    output logic              bit9_out
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

    rx_state_t        state_q, state_n;
    logic [SH_W-1:0]  sh_q, sh_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             sync1_q, line_q, prev_q;
    logic             fall;
    logic [IDX_W-1:0] idx_last;

    assign fall     = prev_q & ~line_q;
    assign idx_last = mode9 ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            line_q  <= 1'b1;
            prev_q  <= 1'b1;
            state_q <= RX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            sync1_q <= rxd;
            line_q  <= sync1_q;
            prev_q  <= line_q;
            state_q <= state_n;
            sh_q    <= sh_n;
            cnt_q   <= cnt_n;
            idx_q   <= idx_n;
        end
    end

    always_comb begin
        state_n = state_q;
        sh_n    = sh_q;
        cnt_n   = cnt_q;
        idx_n   = idx_q;
        fin     = 1'b0;
        if (!enable) begin
            state_n = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (fall) begin
                        cnt_n   = '0;
                        state_n = RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt_q == CNT_MID) begin
                            cnt_n   = '0;
                            idx_n   = '0;
                            state_n = line_q ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_n = '0;
                            sh_n  = {line_q, sh_q[SH_W-1:1]};
                            if (idx_q == idx_last) begin
                                state_n = RX_STOP;
                            end else begin
                                idx_n = idx_q + 1'b1;
                            end
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_n   = '0;
                            fin     = line_q;
                            state_n = RX_IDLE;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_n = RX_IDLE;
            endcase
        end
    end

    assign data_out = mode9 ? sh_q[DATA_W-1:0] : sh_q[SH_W-1:1];
    assign bit9_out = sh_q[SH_W-1];

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_fin,
    input  logic              rx_fin,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    output logic [DATA_W-1:0] rdata,
    output logic              mode9,
    output logic              rx_en,
    output logic              tx_bit9,
    output logic              tx_load,
    output logic              irq_en,
    output logic              tx_done,
    output logic              rx_done
);
    localparam int PAD_W = DATA_W - 7;

    logic              ctrl_wr;
    logic              rx_b9_q;
    logic [DATA_W-1:0] rxbuf_q;

    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
    assign tx_load = wr_en && (addr == ADDR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode9   <= 1'b0;
            rx_en   <= 1'b0;
            tx_bit9 <= 1'b0;
            irq_en  <= 1'b0;
            rx_b9_q <= 1'b0;
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            rxbuf_q <= '0;
        end else begin
            if (ctrl_wr) begin
                mode9   <= wdata[CB_MODE9];
                rx_en   <= wdata[CB_RXEN];
                tx_bit9 <= wdata[CB_TXB9];
                irq_en  <= wdata[CB_IRQEN];
            end
            // hardware events win over a same-cycle software write
            if (rx_fin && mode9)  rx_b9_q <= rx_bit9;
            else if (ctrl_wr)     rx_b9_q <= wdata[CB_RXB9];
            if (tx_fin)           tx_done <= 1'b1;
            else if (ctrl_wr)     tx_done <= wdata[CB_TXDONE];
            if (rx_fin)           rx_done <= 1'b1;
            else if (ctrl_wr)     rx_done <= wdata[CB_RXDONE];
            if (rx_fin)           rxbuf_q <= rx_data;
        end
    end

    always_comb begin
        if (addr == ADDR_DATA) begin
            rdata = rxbuf_q;
        end else begin
            rdata = {{PAD_W{1'b0}}, rx_done, tx_done, irq_en, rx_b9_q,
                     tx_bit9, rx_en, mode9};
        end
    end

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    logic              mode9, rx_en, tx_bit9, tx_load, irq_en;
    logic              tx_done, rx_done;
    logic              tx_busy, tx_fin, rx_fin, rx_bit9;
    logic [DATA_W-1:0] rx_data;

    sio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .tx_fin  (tx_fin),
        .rx_fin  (rx_fin),
        .rx_data (rx_data),
        .rx_bit9 (rx_bit9),
        .rdata   (rdata),
        .mode9   (mode9),
        .rx_en   (rx_en),
        .tx_bit9 (tx_bit9),
        .tx_load (tx_load),
        .irq_en  (irq_en),
        .tx_done (tx_done),
        .rx_done (rx_done)
    );

    sio_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .load      (tx_load),
        .load_data (wdata),
        .mode9     (mode9),
        .bit9      (tx_bit9),
        .txd       (txd),
        .busy      (tx_busy),
        .fin       (tx_fin)
    );

    sio_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rxd      (rxd),
        .enable   (rx_en),
        .mode9    (mode9),
        .fin      (rx_fin),
        .data_out (rx_data),
        .bit9_out (rx_bit9)
    );

    assign irq = irq_en & (tx_done | rx_done);

endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic addr,
    input logic txd,
    input logic tx_busy,
    input logic tx_fin,
    input logic rx_fin,
    input logic rx_en,
    input logic tx_done,
    input logic rx_done
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && !addr;

    assert_tx_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    assert_tx_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && wr_en && addr && !tx_fin) |=> tx_busy);

    assert_rx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fin |-> rx_en);

    assert_txdone_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !ctrl_wr) |=> tx_done);

    assert_rxdone_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !ctrl_wr) |=> rx_done);

    assert_rxdone_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_done && !rx_fin && !ctrl_wr) |=> !rx_done);

endmodule

bind sio_port sio_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .txd     (txd),
    .tx_busy (tx_busy),
    .tx_fin  (tx_fin),
    .rx_fin  (rx_fin),
    .rx_en   (rx_en),
    .tx_done (tx_done),
    .rx_done (rx_done)
);

// File: tb/sio_port_test.sv
module sio_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int TICK_DIV   = 4;
    localparam int BIT        = OSR * TICK_DIV;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int total = 0;
    int bad   = 0;

    sio_port #(.DATA_W(8), .OSR(OSR)) uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd),
        .txd(txd), .irq(irq)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
            tick16 = (cnt == 0);
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic stopv);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = stopv;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic capture_tx(input int nb, output logic [11:0] f);
        int guard = 0;
        f = '0;
        while (txd !== 1'b0 && guard < 4 * BIT) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            f[i] = txd;
            if (i < nb - 1) repeat (BIT) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        reg_read(1'b0, v); chk("R1 ctrl after reset", v, 8'h00);
        reg_read(1'b1, v); chk("R1 data after reset", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 irq low", irq, 1'b0);
    endtask

    task automatic t_tx8;
        logic [11:0] f;
        logic [7:0] v;
        reg_write(1'b0, 8'h10);
        reg_write(1'b1, 8'hA5);
        capture_tx(10, f);
        chk("R2 start bit", f[0], 1'b0);
        chk("R2 data bits", f[8:1], 8'hA5);
        chk("R2 stop bit", f[9], 1'b1);
        repeat (BIT) @(negedge clk);
        reg_read(1'b0, v); chk("R2 tx_done set", v, 8'h30);
        chk("R12 irq with tx_done", irq, 1'b1);
        reg_write(1'b0, 8'h10);
        reg_read(1'b0, v); chk("R11 tx_done cleared by write", v, 8'h10);
        chk("R12 irq after clear", irq, 1'b0);
    endtask

    task automatic t_tx_busy;
        logic [11:0] f;
        int lows = 0;
        reg_write(1'b0, 8'h00);
        reg_write(1'b1, 8'h4B);
        reg_write(1'b1, 8'hFF);
        capture_tx(10, f);
        chk("R4 frame data kept", f[8:1], 8'h4B);
        chk("R4 frame stop", f[9], 1'b1);
        for (int i = 0; i < 2 * BIT; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R4 no second frame", lows, 0);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_tx9;
        logic [11:0] f;
        logic [7:0] v;
        reg_write(1'b0, 8'h05);
        reg_write(1'b1, 8'h5A);
        capture_tx(11, f);
        chk("R3 start bit", f[0], 1'b0);
        chk("R3 data bits", f[8:1], 8'h5A);
        chk("R3 ninth bit", f[9], 1'b1);
        chk("R3 stop bit", f[10], 1'b1);
        repeat (BIT) @(negedge clk);
        reg_read(1'b0, v); chk("R3 tx_done set", v, 8'h25);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_rx9;
        logic [7:0] v;
        reg_write(1'b0, 8'h03);
        send_frame(9'h1C3, 9, 1'b1);
        reg_read(1'b1, v); chk("R6 data low bits", v, 8'hC3);
        reg_read(1'b0, v); chk("R6 ninth bit captured", v, 8'h4B);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_rx8;
        logic [7:0] v;
        reg_write(1'b0, 8'h1A);
        send_frame(9'h096, 8, 1'b1);
        reg_read(1'b1, v); chk("R5 received byte", v, 8'h96);
        reg_read(1'b0, v); chk("R5 rx_done set, ninth kept", v, 8'h5A);
        chk("R12 irq with rx_done", irq, 1'b1);
        reg_read(1'b1, v);
        reg_write(1'b1, 8'h00);
        repeat (12 * BIT) @(negedge clk);
        reg_read(1'b0, v); chk("R11 sticky after read and tx", v, 8'h7A);
        reg_write(1'b0, 8'h7A);
        reg_read(1'b0, v); chk("R11 write of 1 keeps flags", v, 8'h7A);
        reg_write(1'b0, 8'h1A);
        reg_read(1'b0, v); chk("R11 flags cleared", v, 8'h1A);
        chk("R12 irq low after clear", irq, 1'b0);
    endtask

    task automatic t_dbl;
        logic [7:0] v;
        logic [7:0] mid = 8'h00;
        reg_write(1'b0, 8'h02);
        send_frame(9'h011, 8, 1'b1);
        fork
            send_frame(9'h022, 8, 1'b1);
            begin
                repeat (5 * BIT) @(negedge clk);
                reg_read(1'b1, mid);
            end
        join
        chk("R7 latch holds first during second", mid, 8'h11);
        reg_read(1'b1, v); chk("R7 latch takes second", v, 8'h22);
        reg_read(1'b0, v); chk("R7 rx_done set", v, 8'h42);
        reg_write(1'b0, 8'h02);
    endtask

    task automatic t_badstop;
        logic [7:0] v;
        send_frame(9'h077, 8, 1'b0);
        reg_read(1'b1, v); chk("R8 latch unchanged", v, 8'h22);
        reg_read(1'b0, v); chk("R8 no rx_done", v, 8'h02);
    endtask

    task automatic t_glitch;
        logic [7:0] v;
        rxd = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        reg_read(1'b0, v); chk("R9 glitch not a frame", v, 8'h02);
        send_frame(9'h05E, 8, 1'b1);
        reg_read(1'b1, v); chk("R9 next frame accepted", v, 8'h5E);
        reg_read(1'b0, v); chk("R9 rx_done after valid", v, 8'h42);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_rxdis;
        logic [7:0] v;
        send_frame(9'h099, 8, 1'b1);
        reg_read(1'b1, v); chk("R10 latch unchanged", v, 8'h5E);
        reg_read(1'b0, v); chk("R10 no rx_done", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_tx8;
        t_tx_busy;
        t_tx9;
        t_rx9;
        t_rx8;
        t_dbl;
        t_badstop;
        t_glitch;
        t_rxdis;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule